// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a simple request port and a 4M x 16 extended-data-out DRAM. A host issues word or byte reads and writes carrying a 22-bit word address. The controller splits that address into a 12-bit row and a 10-bit column and sends both over one multiplexed address bus. It sequences the row strobe, the two byte-lane column strobes, write enable and output enable, and it returns read data on a one-cycle response pulse.

After an access the row is left open. A later request to the same row goes straight to a column cycle with no new activation. A request to another row first closes the page. An internal timer raises a refresh request at a fixed interval. The controller serves it with a CAS-before-RAS cycle once the access in hand has finished, closing any open page first. Every DRAM timing minimum is a parameter counted in clock cycles.

Top module: `edo_page_ctrl`

## Requirements
- R1: A request's address bits [21:10] are the row, present on `dram_a` when `dram_ras_n` falls. Bits [9:0] are the column, present on `dram_a[9:0]` with `dram_a[11:10]` zero when a column strobe falls.
- R2: `req_be[0]` selects the lower lane (`dram_casl_n`, data bits 7:0) and `req_be[1]` selects the upper lane (`dram_cash_n`, data bits 15:8). Only the selected strobes fall. A `req_be` of 2'b00 is treated as 2'b11.
- R3: Every write is an early write. `dram_we_n` is low at least one cycle before the column strobe falls. While the strobe falls, `dram_dq_oe` is high and `dram_oe_n` is high, and `dram_dq_oe` is never high while `dram_oe_n` is low.
- R4: A read holds `dram_we_n` high and `dram_oe_n` low. Data is captured in the last cycle of column precharge, while `dram_ras_n` is still low and both column strobes are high. `rsp_valid` pulses for one cycle. Lanes that were not enabled return zero in `rsp_rdata`.
- R5: A request to the row that is already open, with no refresh in between, causes no fall of `dram_ras_n`.
- R6: A request to another row, or the first request after a refresh, causes exactly one activation. Both column strobes are high when `dram_ras_n` rises.
- R7: Strobe minimums in clock cycles: column strobe low for at least T_CAS; column strobe high within an open row for at least T_CP; `dram_ras_n` fall to column strobe fall at least T_RCD; `dram_ras_n` low for at least T_RAS and high for at least T_RP.
- R8: Every REF_INTERVAL cycles a refresh falls due. It is performed with both column strobes low before `dram_ras_n` falls and `dram_we_n` high. Successive refreshes stay close to REF_INTERVAL apart.
- R9: A due refresh has priority over new requests at a request boundary. `req_ready` is low from acceptance until the access ends, and it is low throughout a refresh.
- R10: After reset all strobes are high, `dram_dq_oe` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in the upper 12 bits |
| req_be | input | 2 | Byte-lane enables |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| dram_a | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower-lane column strobe, active low |
| dram_cash_n | output | 1 | Upper-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Enables the data driver |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The bench builds the controller with T_RCD=2, T_CAS=2, T_CP=2, T_RAS=6, T_RP=3 and REF_INTERVAL=200. Because every timing count is above one, an off-by-one in any strobe window shows up in the measured pulse widths. The short refresh interval makes refresh fall due repeatedly in the middle of the address sweep, with the page open, closed, on a hit and on a miss. The sweep covers rows 0, 1, 2 and 4095 and columns 0, 5 and 1023, with every byte-enable code, so both address extremes and all lane combinations pass through the DRAM model.

// File: rtl/edo_pkg.sv
package edo_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ACT,
      ST_COL,
      ST_CAS,
      ST_CP,
      ST_OPEN,
      ST_PRE,
      ST_RFC,
      ST_RFR,
      ST_RFP
   } edo_st_e;

   function automatic logic st_ras_low(edo_st_e s);
      return (s == ST_ACT) || (s == ST_COL) || (s == ST_CAS) ||
             (s == ST_CP) || (s == ST_OPEN) || (s == ST_RFR);
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
   parameter int INTERVAL = 780
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pend
);
   localparam int CW = $clog2(INTERVAL);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= CW'(INTERVAL - 1);
         pend <= 1'b0;
      end else if (cnt == '0) begin
         cnt  <= CW'(INTERVAL - 1);
         pend <= 1'b1;
      end else begin
         cnt <= cnt - 1'b1;
         if (ack) pend <= 1'b0;
      end
   end
endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
   parameter int ROW_W = 12,
   parameter int COL_W = 10
) (
   input  logic             sel_col,
   input  logic [ROW_W-1:0] row,
   input  logic [COL_W-1:0] col,
   output logic [ROW_W-1:0] a
);
   logic [ROW_W-1:0] col_ext;

   if (ROW_W > COL_W) begin : g_pad
      assign col_ext = {{(ROW_W - COL_W){1'b0}}, col};
   end else begin : g_same
      assign col_ext = col;
   end

   assign a = sel_col ? col_ext : row;
endmodule

// File: rtl/edo_lane_io.sv
module edo_lane_io #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cas_on,
   input  logic              lane_en,
   input  logic              sample,
   input  logic [LANE_W-1:0] dq_lane,
   output logic              cas_n,
   output logic [LANE_W-1:0] rd_lane
);
   assign cas_n = !(cas_on && lane_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_lane <= '0;
      else if (sample) rd_lane <= lane_en ? dq_lane : '0;
   end
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
   import edo_pkg::*;
#(
   parameter int ROW_W        = 12,
   parameter int COL_W        = 10,
   parameter int LANE_W       = 8,
   parameter int T_RCD        = 2,
   parameter int T_CAS        = 1,
   parameter int T_CP         = 1,
   parameter int T_RAS        = 3,
   parameter int T_RP         = 2,
   parameter int T_CSR        = 1,
   parameter int REF_INTERVAL = 780
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic                      req_write,
   input  logic [ROW_W+COL_W-1:0]    req_addr,
   input  logic [1:0]                req_be,
   input  logic [2*LANE_W-1:0]       req_wdata,
   output logic                      rsp_valid,
   output logic [2*LANE_W-1:0]       rsp_rdata,
   output logic [ROW_W-1:0]          dram_a,
   output logic                      dram_ras_n,
   output logic                      dram_casl_n,
   output logic                      dram_cash_n,
   output logic                      dram_we_n,
   output logic                      dram_oe_n,
   output logic [2*LANE_W-1:0]       dram_dq_out,
   output logic                      dram_dq_oe,
   input  logic [2*LANE_W-1:0]       dram_dq_in
);
   localparam int LANES  = 2;
   localparam int T_MAX  = imax(imax(imax(T_RCD, T_CAS), imax(T_CP, T_RAS)), imax(T_RP, T_CSR));
   localparam int CNT_W  = $clog2(T_MAX + 1);
   localparam int RAS_W  = $clog2(T_RAS + 1) + 1;

   if (ROW_W < COL_W) begin : g_bad_addr
      $error("edo_page_ctrl: ROW_W must be at least COL_W");
   end
   if (T_RCD < 1 || T_CAS < 1 || T_CP < 1 || T_RAS < 1 || T_RP < 1 || T_CSR < 1) begin : g_bad_t
      $error("edo_page_ctrl: timing counts must be at least one cycle");
   end
   if (REF_INTERVAL < 2 * T_MAX + 8) begin : g_bad_ref
      $error("edo_page_ctrl: REF_INTERVAL too short for the timing counts");
   end

   edo_st_e          st, st_n;
   logic [CNT_W-1:0] cnt, ld_v;
   logic             ld, done;
   logic             have, cur_write;
   logic [ROW_W-1:0] cur_row, open_row;
   logic [COL_W-1:0] cur_col;
   logic [LANES-1:0] cur_be, strobe_en, cas_n_v;
   logic [2*LANE_W-1:0] cur_wdata;
   logic [RAS_W-1:0] ras_cnt;
   logic             ras_low, ras_ok, hit, fire;
   logic             ref_pend, ref_ack, in_ref, cas_on, sel_col, sample;

   assign done    = (cnt == '0);
   assign hit     = (cur_row == open_row);
   assign ras_low = st_ras_low(st);
   assign ras_ok  = (ras_cnt >= RAS_W'(T_RAS));
   assign req_ready = ((st == ST_IDLE) || (st == ST_OPEN)) && !have && !ref_pend;
   assign fire    = req_valid && req_ready;
   assign sample  = (st == ST_CP) && done && !cur_write;

   edo_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
      .clk (clk), .rst_n (rst_n), .ack (ref_ack), .pend (ref_pend)
   );

   always_comb begin
      st_n    = st;
      ld      = 1'b0;
      ld_v    = '0;
      ref_ack = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (have) begin
               st_n = ST_ACT; ld = 1'b1; ld_v = CNT_W'(T_RCD - 1);
            end else if (ref_pend) begin
               st_n = ST_RFC; ld = 1'b1; ld_v = CNT_W'(T_CSR - 1); ref_ack = 1'b1;
            end
         end
         ST_ACT:  if (done) st_n = ST_COL;
         ST_COL:  begin st_n = ST_CAS; ld = 1'b1; ld_v = CNT_W'(T_CAS - 1); end
         ST_CAS:  if (done) begin st_n = ST_CP; ld = 1'b1; ld_v = CNT_W'(T_CP - 1); end
         ST_CP:   if (done) st_n = ST_OPEN;
         ST_OPEN: begin
            if (have && hit) begin
               st_n = ST_COL;
            end else if ((have || ref_pend) && ras_ok) begin
               st_n = ST_PRE; ld = 1'b1; ld_v = CNT_W'(T_RP - 1);
            end
         end
         ST_PRE: begin
            if (done) begin
               if (have) begin
                  st_n = ST_ACT; ld = 1'b1; ld_v = CNT_W'(T_RCD - 1);
               end else if (ref_pend) begin
                  st_n = ST_RFC; ld = 1'b1; ld_v = CNT_W'(T_CSR - 1); ref_ack = 1'b1;
               end else begin
                  st_n = ST_IDLE;
               end
            end
         end
         ST_RFC:  if (done) begin st_n = ST_RFR; ld = 1'b1; ld_v = CNT_W'(T_RAS - 1); end
         ST_RFR:  if (done) begin st_n = ST_RFP; ld = 1'b1; ld_v = CNT_W'(T_RP - 1); end
         ST_RFP:  if (done) st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         have      <= 1'b0;
         cur_write <= 1'b0;
         cur_row   <= '0;
         cur_col   <= '0;
         cur_be    <= '1;
         cur_wdata <= '0;
         open_row  <= '0;
         ras_cnt   <= '0;
         rsp_valid <= 1'b0;
      end else begin
         st        <= st_n;
         rsp_valid <= sample;
         if (ld)         cnt <= ld_v;
         else if (!done) cnt <= cnt - 1'b1;
         if (!ras_low)    ras_cnt <= '0;
         else if (!ras_ok) ras_cnt <= ras_cnt + 1'b1;
         if (st_n == ST_ACT && st != ST_ACT) open_row <= cur_row;
         if (fire) begin
            have      <= 1'b1;
            cur_write <= req_write;
            cur_row   <= req_addr[COL_W +: ROW_W];
            cur_col   <= req_addr[COL_W-1:0];
            cur_be    <= (req_be == '0) ? '1 : req_be;
            cur_wdata <= req_wdata;
         end else if (st == ST_CP && done) begin
            have <= 1'b0;
         end
      end
   end

   assign in_ref    = (st == ST_RFC) || (st == ST_RFR);
   assign cas_on    = (st == ST_CAS) || in_ref;
   assign strobe_en = in_ref ? '1 : cur_be;
   assign sel_col   = (st == ST_COL) || (st == ST_CAS) || (st == ST_CP) || (st == ST_OPEN);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      edo_lane_io #(.LANE_W(LANE_W)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .cas_on  (cas_on),
         .lane_en (strobe_en[i]),
         .sample  (sample),
         .dq_lane (dram_dq_in[i*LANE_W +: LANE_W]),
         .cas_n   (cas_n_v[i]),
         .rd_lane (rsp_rdata[i*LANE_W +: LANE_W])
      );
   end

   edo_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_amux (
      .sel_col (sel_col), .row (cur_row), .col (cur_col), .a (dram_a)
   );

   assign dram_ras_n  = !ras_low;
   assign dram_casl_n = cas_n_v[0];
   assign dram_cash_n = cas_n_v[1];
   assign dram_we_n   = !(cur_write && ((st == ST_COL) || (st == ST_CAS)));
   assign dram_oe_n   = !(!cur_write && ((st == ST_CAS) || (st == ST_CP)));
   assign dram_dq_oe  = cur_write && ((st == ST_COL) || (st == ST_CAS));
   assign dram_dq_out = cur_wdata;
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic rsp_valid,
   input logic ras_n,
   input logic casl_n,
   input logic cash_n,
   input logic we_n,
   input logic oe_n,
   input logic dq_oe
);
   // R3
   early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($fell(casl_n) || $fell(cash_n)) && !we_n) |-> $past(!we_n));

   // R3
   no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> oe_n);

   // R4
   edo_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!oe_n && !ras_n && we_n && casl_n && cash_n));

   // R8
   cbr_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !casl_n) |-> (we_n && !cash_n));

   // R8
   cbr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !casl_n) |-> $past(!casl_n && !cash_n));

   // R6
   close_cas_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (casl_n && cash_n));

   // R9
   accept_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
endmodule

bind edo_page_ctrl edo_page_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .ras_n     (dram_ras_n),
   .casl_n    (dram_casl_n),
   .cash_n    (dram_cash_n),
   .we_n      (dram_we_n),
   .oe_n      (dram_oe_n),
   .dq_oe     (dram_dq_oe)
);

// File: tb/sim_edo_page_ctrl.sv
module sim_edo_page_ctrl;
   localparam int ROW_W = 12, COL_W = 10, LANE_W = 8;
   localparam int T_RCD = 2, T_CAS = 2, T_CP = 2, T_RAS = 6, T_RP = 3, T_CSR = 1;
   localparam int REF_INTERVAL = 200;
   localparam int AW = ROW_W + COL_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0] req_be = '0;
   logic [15:0] req_wdata = '0;
   logic req_ready, rsp_valid;
   logic [15:0] rsp_rdata, dram_dq_out;
   logic [15:0] dram_dq_in = 16'hDEAD;
   logic [ROW_W-1:0] dram_a;
   logic dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n, dram_dq_oe;

   always #10 clk = ~clk;

   edo_page_ctrl #(
      .ROW_W(ROW_W), .COL_W(COL_W), .LANE_W(LANE_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
      .T_CP(T_CP), .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR), .REF_INTERVAL(REF_INTERVAL)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_a(dram_a),
      .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n), .dram_cash_n(dram_cash_n),
      .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
      .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
   );

   int errors = 0, checks = 0;
   bit finished = 1'b0;

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // expectations shared with the DRAM model
   logic [ROW_W-1:0] exp_row = '0;
   logic [COL_W-1:0] exp_col = '0;
   logic [1:0]       exp_be  = 2'b11;

   // DRAM model
   logic [15:0] mem [int unsigned];
   int act_cnt = 0, ref_cnt = 0;
   longint cyc = 0, last_ref_cyc = -1;

   function automatic logic [15:0] mem_rd(int unsigned k);
      return mem.exists(k) ? mem[k] : 16'h0000;
   endfunction

   logic p_ras, p_we;
   logic [1:0] p_cas;
   int ras_run;
   int cas_run [2];
   bit in_ref;
   logic [ROW_W-1:0] m_row;
   logic [COL_W-1:0] m_col;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_ras = 1'b1; p_we = 1'b1; p_cas = 2'b11;
         ras_run = 100; cas_run[0] = 100; cas_run[1] = 100;
         in_ref = 1'b0; m_row = '0; m_col = '0; cyc = 0;
         dram_dq_in = 16'hDEAD;
      end else begin
         logic [1:0] cas_now, fell;
         int unsigned key;
         cyc++;
         cas_now = {dram_cash_n, dram_casl_n};
         if (dram_ras_n == p_ras) ras_run++;
         else begin
            if (p_ras == 1'b0) begin
               check(ras_run >= T_RAS, "R7", "RAS low width", ras_run, T_RAS);
            end else begin
               check(ras_run >= T_RP, "R7", "RAS high width", ras_run, T_RP);
               if (cas_now == 2'b00) begin
                  ref_cnt++;
                  in_ref = 1'b1;
                  check(dram_we_n == 1'b1, "R8", "WE_n during CBR", dram_we_n, 1);
                  check(p_cas == 2'b00, "R8", "CAS before RAS", p_cas, 0);
                  if (last_ref_cyc >= 0)
                     check((cyc - last_ref_cyc >= REF_INTERVAL - 40) && (cyc - last_ref_cyc <= REF_INTERVAL + 40),
                           "R8", "refresh spacing", cyc - last_ref_cyc, REF_INTERVAL);
                  else
                     check(cyc <= REF_INTERVAL + 40, "R8", "first refresh time", cyc, REF_INTERVAL);
                  last_ref_cyc = cyc;
               end else begin
                  act_cnt++;
                  m_row = dram_a;
                  check(dram_a == exp_row, "R1", "row address", dram_a, exp_row);
               end
            end
            ras_run = 1;
         end
         if (dram_ras_n) in_ref = 1'b0;
         if (in_ref) check(!req_ready, "R9", "ready during refresh", req_ready, 0);
         for (int i = 0; i < 2; i++) begin
            if (cas_now[i] == p_cas[i]) cas_run[i]++;
            else begin
               if (p_cas[i] == 1'b0)
                  check(cas_run[i] >= T_CAS, "R7", "CAS low width", cas_run[i], T_CAS);
               else if (!dram_ras_n && !in_ref && cas_run[i] < ras_run)
                  check(cas_run[i] >= T_CP, "R7", "CAS precharge width", cas_run[i], T_CP);
               cas_run[i] = 1;
            end
         end
         fell = p_cas & ~cas_now;
         if (fell != 2'b00 && !dram_ras_n && !in_ref) begin
            check(fell == exp_be, "R2", "lane strobes", fell, exp_be);
            check(dram_a == {2'b00, exp_col}, "R1", "column address", dram_a, {2'b00, exp_col});
            check(ras_run - 1 >= T_RCD, "R7", "RAS to CAS delay", ras_run - 1, T_RCD);
            m_col = dram_a[COL_W-1:0];
            key = {m_row, m_col};
            if (!dram_we_n) begin
               logic [15:0] w;
               check(p_we == 1'b0, "R3", "WE_n low before CAS", p_we, 0);
               check(dram_dq_oe && dram_oe_n, "R3", "drive with OE_n high",
                     {dram_dq_oe, dram_oe_n}, 2'b11);
               w = mem_rd(key);
               if (fell[0]) w[7:0]  = dram_dq_out[7:0];
               if (fell[1]) w[15:8] = dram_dq_out[15:8];
               mem[key] = w;
            end
         end
         key = {m_row, m_col};
         dram_dq_in = (!dram_ras_n && !dram_oe_n && dram_we_n) ? mem_rd(key) : 16'hDEAD;
         p_ras = dram_ras_n; p_cas = cas_now; p_we = dram_we_n;
      end
   end

   // bench expectations
   logic [15:0] shadow [int unsigned];
   int last_row = -1, last_act = 0, last_ref = 0;

   task automatic access(bit wr, logic [AW-1:0] addr, logic [1:0] be, logic [15:0] wd);
      logic [1:0] eb;
      int exp_act;
      eb = (be == 2'b00) ? 2'b11 : be;
      exp_row = addr[AW-1:COL_W];
      exp_col = addr[COL_W-1:0];
      exp_be  = eb;
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(!req_ready, "R9", "ready low after accept", req_ready, 0);
      if (wr) begin
         logic [15:0] s;
         s = shadow.exists(addr) ? shadow[addr] : 16'h0;
         if (eb[0]) s[7:0]  = wd[7:0];
         if (eb[1]) s[15:8] = wd[15:8];
         shadow[addr] = s;
         while (dram_we_n) @(negedge clk);
         while (!dram_we_n) @(negedge clk);
      end else begin
         logic [15:0] e, s;
         while (!rsp_valid) @(negedge clk);
         s = shadow.exists(addr) ? shadow[addr] : 16'h0;
         e = {eb[1] ? s[15:8] : 8'h00, eb[0] ? s[7:0] : 8'h00};
         check(rsp_rdata == e, "R4", "read data", rsp_rdata, e);
         @(negedge clk);
         check(!rsp_valid, "R4", "one-cycle response", rsp_valid, 0);
      end
      exp_act = (int'(addr[AW-1:COL_W]) != last_row || ref_cnt != last_ref) ? 1 : 0;
      if (exp_act == 0) check(act_cnt - last_act == 0, "R5", "page hit activations", act_cnt - last_act, 0);
      else check(act_cnt - last_act == 1, "R6", "page miss activations", act_cnt - last_act, 1);
      last_row = int'(addr[AW-1:COL_W]);
      last_act = act_cnt;
      last_ref = ref_cnt;
   endtask

   int rows [4] = '{0, 1, 2, 4095};
   int cols [3] = '{0, 5, 1023};

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10
      check({dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n} == 5'b11111,
            "R10", "strobes after reset", {dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n}, 5'h1f);
      check(!dram_dq_oe, "R10", "dq_oe after reset", dram_dq_oe, 0);
      check(req_ready, "R10", "ready after reset", req_ready, 1);

      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 3; c++) begin
            logic [AW-1:0] a;
            a = AW'((rows[r] << COL_W) | cols[c]);
            access(1'b1, a, 2'b11, 16'(a * 37 + 22'h1357));
         end
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 3; c++) begin
            logic [AW-1:0] a;
            a = AW'((rows[r] << COL_W) | cols[c]);
            access(1'b1, a, 2'(c + 1), 16'(a * 11 + 22'h2468));
         end
      for (int pass = 0; pass < 2; pass++)
         for (int c = 0; c < 3; c++)
            for (int r = 0; r < 4; r++)
               for (int be = 0; be < 4; be++) begin
                  logic [AW-1:0] a;
                  a = (pass == 0) ? AW'((rows[r] << COL_W) | cols[c])
                                  : AW'((rows[3 - r] << COL_W) | cols[2 - c]);
                  access(1'b0, a, 2'(be), 16'h0);
               end
      begin
         int r0;
         r0 = ref_cnt;
         repeat (1000) @(negedge clk);
         check(ref_cnt - r0 >= 4, "R8", "refreshes while idle", ref_cnt - r0, 4);
      end
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
         summary();
         $finish;
      end
   end
endmodule